// File: doc/BRIEF.md
# Parallel Port Nibble-Mode Receiver

This block is the host side of the reverse channel of a parallel port that is already in nibble mode. The peripheral has no data bus in this direction. It returns each byte as two 4-bit halves on four of its status lines and uses its acknowledge line as the strobe. The host asks for each half by pulling its auto-feed output low and confirms capture by releasing it. Two halves form a byte, which is offered on a valid/ready stream output.

A transfer starts with a one-cycle `start` pulse that carries a byte count. It ends in one of three ways: the requested number of bytes arrived, the peripheral did not answer in time, or it failed to finish the handshake after the last half of a byte. At the end the block pulses `done`, sets a status code and reports how many bytes it delivered. Timeouts are counted in ticks of `TICK_CYCLES` clocks. The wait for the first half of a byte may last much longer than the other waits, because the peripheral may have no data ready yet.

Back-pressure rule: `m_data` holds steady while `m_valid` is high and `m_ready` is low. The output holds one byte. The block does not ask for the next byte until the held byte is taken, so a stalled consumer stalls the cable handshake and no byte is lost.

Top module: `nibble_rx`

## Requirements
- R1: After reset, `autofd_n` is high, `m_valid` and `busy` are low, `xfer_status` is 0 and `delivered` is 0.
- R2: A nibble is requested by driving `autofd_n` low. It stays low until the synchronized `st_nack` is seen low, and it returns high when the nibble is captured.
- R3: A nibble is the bits {st_busy, st_perror, st_select, st_nfault}, with st_nfault as bit 0 and st_busy as bit 3. The first nibble of a byte fills `m_data[3:0]` and the second fills `m_data[7:4]`.
- R4: If `st_nack` does not go low within FIRST_TICKS ticks of a first-nibble request, the transfer ends with `xfer_status` = 1 (timeout), about FIRST_TICKS*TICK_CYCLES cycles after the request, and no byte is emitted.
- R5: The wait for `st_nack` high after the first nibble and the wait for the second nibble are each limited to SHORT_TICKS ticks. Missing either ends the transfer with status 1. A first nibble that arrives later than SHORT_TICKS but within FIRST_TICKS is still accepted.
- R6: If `st_nack` does not return high within SHORT_TICKS after the second nibble, the transfer ends with `xfer_status` = 2 (I/O error). The completed byte is still emitted and counted.
- R7: After `byte_count` bytes the block pulses `done` once with `xfer_status` = 0 and `delivered` = `byte_count`, and it never delivers more than requested.
- R8: While a byte waits on the output, `m_valid` stays high, `m_data` is stable and `autofd_n` stays high. The next request starts only after the byte is taken.
- R9: A start with `byte_count` = 0 gives a `done` pulse with status 0 and `delivered` = 0, and no nibble is requested.
- R10: A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a transfer |
| byte_count | input | CNT_W | Number of bytes to receive, sampled with `start` |
| st_nack | input | 1 | Peripheral acknowledge line (nibble strobe), asynchronous |
| st_busy | input | 1 | Status line carrying nibble bit 3 |
| st_perror | input | 1 | Status line carrying nibble bit 2 |
| st_select | input | 1 | Status line carrying nibble bit 1 |
| st_nfault | input | 1 | Status line carrying nibble bit 0 |
| autofd_n | output | 1 | Host request line; low asks for a nibble |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Consumer accepts the byte |
| m_data | output | 8 | Assembled byte |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| xfer_status | output | 2 | Result of the last transfer: 0 ok, 1 timeout, 2 I/O error |
| delivered | output | CNT_W | Bytes emitted in the current or last transfer |

## Verification
The bench builds the block with TICK_CYCLES = 4, FIRST_TICKS = 20 and SHORT_TICKS = 6. This makes the long first-nibble window 80 cycles and the short windows 24 cycles. With these values a first nibble can be delayed past the short window and still be accepted, a peripheral that never answers times out within a run of a few hundred cycles, and the timeout moment can be checked against the long limit. Each of the three ways a transfer can end, the zero-count case and a stalled consumer are each driven by their own scenario.

// File: rtl/nrx_pkg.sv
package nrx_pkg;
  localparam int NRX_NIB_W  = 4;
  localparam int NRX_BYTE_W = 2 * NRX_NIB_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOT,
    ST_REQ_LO,
    ST_ACK_LO,
    ST_REQ_HI,
    ST_ACK_HI
  } nrx_state_e;

  typedef enum logic [1:0] {
    XS_OK      = 2'd0,
    XS_TIMEOUT = 2'd1,
    XS_IOERR   = 2'd2
  } nrx_status_e;
endpackage

// File: rtl/nrx_sync.sv
module nrx_sync #(
  parameter int               WIDTH     = 5,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [1:0] stage;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage <= {2{RESET_VAL[i]}};
      else        stage <= {stage[0], din[i]};
    end
    assign dout[i] = stage[1];
  end
endmodule

// File: rtl/nrx_timer.sv
module nrx_timer #(
  parameter int TICK_CYCLES = 100,
  parameter int LONG_TICKS  = 2000,
  parameter int SHORT_TICKS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sel_long,
  output logic expired
);
  localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int CNT_W = $clog2(LONG_TICKS + 1);

  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             tick;

  assign tick    = (pre == PRE_W'(TICK_CYCLES - 1));
  assign limit   = sel_long ? CNT_W'(LONG_TICKS) : CNT_W'(SHORT_TICKS);
  assign expired = (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      cnt <= '0;
    end else if (clr) begin
      pre <= '0;
      cnt <= '0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick && !expired) cnt <= cnt + 1'b1;
    end
  end

  // R4
  expiry_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !clr) |=> expired);
endmodule

// File: rtl/nrx_out.sv
module nrx_out #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (push) begin
      valid <= 1'b1;
      data  <= push_data;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !valid);

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(data)));
endmodule

// File: rtl/nibble_rx.sv
module nibble_rx
  import nrx_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int TICK_CYCLES = 100,
  parameter int FIRST_TICKS = 2000,
  parameter int SHORT_TICKS = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [CNT_W-1:0]      byte_count,
  input  logic                  st_nack,
  input  logic                  st_busy,
  input  logic                  st_perror,
  input  logic                  st_select,
  input  logic                  st_nfault,
  output logic                  autofd_n,
  output logic                  m_valid,
  input  logic                  m_ready,
  output logic [NRX_BYTE_W-1:0] m_data,
  output logic                  busy,
  output logic                  done,
  output logic [1:0]            xfer_status,
  output logic [CNT_W-1:0]      delivered
);
  localparam int SYNC_W = NRX_NIB_W + 1;

  logic [SYNC_W-1:0]    sync_q;
  logic                 nack_s;
  logic [NRX_NIB_W-1:0] nib_s;

  nrx_sync #(.WIDTH(SYNC_W), .RESET_VAL('1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({st_nack, st_busy, st_perror, st_select, st_nfault}),
    .dout (sync_q)
  );
  assign nack_s = sync_q[SYNC_W-1];
  assign nib_s  = sync_q[NRX_NIB_W-1:0];

  nrx_state_e           state, nxt;
  logic [CNT_W-1:0]     remaining, req_q;
  logic [NRX_NIB_W-1:0] lo_q;
  logic                 push, finish, expired, tmr_clr;
  nrx_status_e          fin_code;

  always_comb begin
    nxt      = state;
    push     = 1'b0;
    finish   = 1'b0;
    fin_code = XS_OK;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (byte_count == '0) finish = 1'b1;
          else                  nxt    = ST_SLOT;
        end
      end
      ST_SLOT:   if (!m_valid) nxt = ST_REQ_LO;
      ST_REQ_LO: begin
        if (!nack_s) nxt = ST_ACK_LO;
        else if (expired) begin
          finish = 1'b1; fin_code = XS_TIMEOUT; nxt = ST_IDLE;
        end
      end
      ST_ACK_LO: begin
        if (nack_s) nxt = ST_REQ_HI;
        else if (expired) begin
          finish = 1'b1; fin_code = XS_TIMEOUT; nxt = ST_IDLE;
        end
      end
      ST_REQ_HI: begin
        if (!nack_s) begin
          push = 1'b1; nxt = ST_ACK_HI;
        end else if (expired) begin
          finish = 1'b1; fin_code = XS_TIMEOUT; nxt = ST_IDLE;
        end
      end
      ST_ACK_HI: begin
        if (nack_s) begin
          if (remaining == CNT_W'(1)) begin
            finish = 1'b1; nxt = ST_IDLE;
          end else begin
            nxt = ST_SLOT;
          end
        end else if (expired) begin
          finish = 1'b1; fin_code = XS_IOERR; nxt = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign tmr_clr = (nxt != state);

  nrx_timer #(
    .TICK_CYCLES(TICK_CYCLES),
    .LONG_TICKS (FIRST_TICKS),
    .SHORT_TICKS(SHORT_TICKS)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (tmr_clr),
    .sel_long(state == ST_REQ_LO),
    .expired (expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      remaining   <= '0;
      req_q       <= '0;
      lo_q        <= '0;
      delivered   <= '0;
      done        <= 1'b0;
      xfer_status <= XS_OK;
    end else begin
      state <= nxt;
      done  <= finish;
      if (finish) xfer_status <= fin_code;
      if (state == ST_IDLE && start) begin
        remaining <= byte_count;
        req_q     <= byte_count;
        delivered <= '0;
      end
      if (state == ST_REQ_LO && !nack_s) lo_q <= nib_s;
      if (push) delivered <= delivered + 1'b1;
      if (state == ST_ACK_HI && nack_s) remaining <= remaining - 1'b1;
    end
  end

  nrx_out #(.DATA_W(NRX_BYTE_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_data({nib_s, lo_q}),
    .ready    (m_ready),
    .valid    (m_valid),
    .data     (m_data)
  );

  assign busy     = (state != ST_IDLE);
  assign autofd_n = !(state == ST_REQ_LO || state == ST_REQ_HI);

  // R7
  delivered_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (delivered <= req_q));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state == ST_IDLE));

  // R8
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLOT && m_valid) |=> (state == ST_SLOT));

  // R2
  request_after_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> autofd_n);
endmodule

// File: tb/nibble_rx_test.sv
`timescale 1ns/1ps
module nibble_rx_test;
  localparam int CW = 16;
  localparam int TC = 4;
  localparam int FT = 20;
  localparam int ST = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] byte_count = '0;
  logic          st_nack = 1'b1, st_busy = 1'b1, st_perror = 1'b1;
  logic          st_select = 1'b1, st_nfault = 1'b1;
  logic          autofd_n, m_valid, busy, done;
  logic          m_ready = 1'b0;
  logic [7:0]    m_data;
  logic [1:0]    xfer_status;
  logic [CW-1:0] delivered;

  int checks = 0;
  int failures = 0;
  int done_cnt = 0;

  always #2.5 clk = ~clk;

  nibble_rx #(.CNT_W(CW), .TICK_CYCLES(TC), .FIRST_TICKS(FT), .SHORT_TICKS(ST)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .st_nack(st_nack), .st_busy(st_busy), .st_perror(st_perror),
    .st_select(st_select), .st_nfault(st_nfault), .autofd_n(autofd_n),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .busy(busy),
    .done(done), .xfer_status(xfer_status), .delivered(delivered)
  );

  always @(negedge clk) if (done === 1'b1) done_cnt++;

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
    $finish;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_autofd(input logic lvl, input int maxc, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < maxc; i++) begin
      if (autofd_n === lvl) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic send_nibble(input logic [3:0] n, input int dly, input bit release_ack,
                             output bit ok);
    wait_autofd(1'b0, 400, ok);
    if (!ok) return;
    tick(dly);
    {st_busy, st_perror, st_select, st_nfault} = n;
    tick(1);
    st_nack = 1'b0;
    wait_autofd(1'b1, 40, ok);
    if (release_ack) begin
      tick(1);
      st_nack = 1'b1;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int dly, input bit last_release,
                           output bit ok);
    send_nibble(b[3:0], dly, 1'b1, ok);
    if (ok) send_nibble(b[7:4], 1, last_release, ok);
  endtask

  task automatic start_xfer(input int cnt, output int base);
    base = done_cnt;
    start = 1'b1;
    byte_count = CW'(cnt);
    tick(1);
    start = 1'b0;
  endtask

  task automatic take_byte(input logic [7:0] exp, input string req);
    int n = 0;
    while (m_valid !== 1'b1 && n < 60) begin tick(1); n++; end
    check({req, " byte valid"}, int'(m_valid), 1);
    check({req, " byte value"}, int'(m_data), int'(exp));
    m_ready = 1'b1;
    tick(1);
    m_ready = 1'b0;
  endtask

  task automatic wait_done(input int base, input int maxc, output int cyc);
    cyc = 0;
    while (done_cnt == base && cyc < maxc) begin tick(1); cyc++; end
    tick(1);
  endtask

  task automatic t_reset;
    check("R1 autofd_n", int'(autofd_n), 1);
    check("R1 m_valid", int'(m_valid), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 status", int'(xfer_status), 0);
    check("R1 delivered", int'(delivered), 0);
  endtask

  task automatic t_single;
    int base, cyc; bit ok;
    start_xfer(1, base);
    wait_autofd(1'b0, 20, ok);
    check("R2 request low", int'(ok), 1);
    tick(8);
    check("R2 request held", int'(autofd_n), 0);
    send_byte(8'hA5, 0, 1'b1, ok);
    check("R2 handshake", int'(ok), 1);
    take_byte(8'hA5, "R3");
    wait_done(base, 100, cyc);
    check("R7 status ok", int'(xfer_status), 0);
    check("R7 delivered", int'(delivered), 1);
  endtask

  task automatic t_multi;
    int base, cyc; bit ok;
    logic [7:0] seq [3] = '{8'h3C, 8'h81, 8'hF0};
    start_xfer(3, base);
    for (int i = 0; i < 3; i++) begin
      send_byte(seq[i], 2, 1'b1, ok);
      check("R3 handshake", int'(ok), 1);
      tick(12);
      check("R8 no request while held", int'(autofd_n), 1);
      check("R8 held byte", int'(m_data), int'(seq[i]));
      take_byte(seq[i], "R3");
    end
    wait_done(base, 100, cyc);
    check("R7 status ok", int'(xfer_status), 0);
    check("R7 delivered count", int'(delivered), 3);
    check("R7 one done pulse", done_cnt - base, 1);
  endtask

  task automatic t_slow_first;
    int base, cyc; bit ok;
    start_xfer(1, base);
    send_byte(8'h6E, 60, 1'b1, ok);
    check("R5 slow first accepted", int'(ok), 1);
    take_byte(8'h6E, "R5");
    wait_done(base, 100, cyc);
    check("R5 status ok", int'(xfer_status), 0);
  endtask

  task automatic t_first_timeout;
    int base, cyc;
    start_xfer(2, base);
    wait_done(base, 400, cyc);
    check("R4 status timeout", int'(xfer_status), 1);
    check("R4 delivered", int'(delivered), 0);
    check("R4 no byte", int'(m_valid), 0);
    check("R4 window", int'(cyc >= FT * TC - 6 && cyc <= FT * TC + 12), 1);
  endtask

  task automatic t_short_timeout;
    int base, cyc; bit ok;
    start_xfer(1, base);
    send_nibble(4'h9, 2, 1'b0, ok);
    wait_done(base, 200, cyc);
    check("R5 status timeout", int'(xfer_status), 1);
    check("R5 delivered", int'(delivered), 0);
    check("R5 no byte", int'(m_valid), 0);
    st_nack = 1'b1;
    tick(4);
  endtask

  task automatic t_ioerr;
    int base, cyc; bit ok;
    start_xfer(2, base);
    send_byte(8'hC3, 2, 1'b0, ok);
    wait_done(base, 200, cyc);
    check("R6 status ioerr", int'(xfer_status), 2);
    check("R6 delivered", int'(delivered), 1);
    take_byte(8'hC3, "R6");
    st_nack = 1'b1;
    tick(4);
  endtask

  task automatic t_zero;
    int base;
    start_xfer(0, base);
    tick(3);
    check("R9 done", done_cnt - base, 1);
    check("R9 status ok", int'(xfer_status), 0);
    check("R9 delivered", int'(delivered), 0);
    check("R9 idle", int'(busy), 0);
    check("R9 no request", int'(autofd_n), 1);
  endtask

  task automatic t_busy_ignore;
    int base, cyc; bit ok;
    start_xfer(1, base);
    tick(2);
    start = 1'b1; byte_count = CW'(5);
    tick(1);
    start = 1'b0;
    send_byte(8'h5A, 1, 1'b1, ok);
    take_byte(8'h5A, "R10");
    wait_done(base, 100, cyc);
    check("R10 delivered", int'(delivered), 1);
    check("R10 status ok", int'(xfer_status), 0);
    check("R10 idle after", int'(busy), 0);
    check("R10 one done", done_cnt - base, 1);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_single();
    t_multi();
    t_slow_first();
    t_first_timeout();
    t_short_timeout();
    t_ioerr();
    t_zero();
    t_busy_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule